// File: doc/BRIEF.md
# Byte ALU with Status Flags

This block is the arithmetic and logic stage of a small 8-bit processor datapath. The sequencer presents the accumulator value, a second operand byte and an operation code. In the same cycle the block returns the result byte and tells the sequencer whether that byte is to be written back into the accumulator. The five condition flags are kept in a register inside the block. The register loads its next value on the clock edge where the operation is marked valid. Carry-in, borrow-in, rotate-through-carry and decimal adjust all read the flags currently held in that register.

The operation code is five bits wide. Codes 0 to 7 keep the order of the three-bit operation field of the register/memory arithmetic group, because the instruction decoder passes that field through unchanged: 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 AND, 5 XOR, 6 OR, 7 compare. The remaining codes are 8 increment, 9 decrement, 10 rotate left, 11 rotate right, 12 rotate left through carry, 13 rotate right through carry, 14 decimal adjust, 15 complement accumulator, 16 complement carry and 17 set carry. Codes 18 to 31 are no-operations.

Top module: `byte_alu`

## Requirements
- R1: Add (code 0) returns A+B and add with carry (code 1) returns A+B+CY, both truncated to 8 bits. CY is set to the carry out of bit 7 and AC to the carry out of bit 3.
- R2: Subtract (code 2) returns A-B and subtract with borrow (code 3) returns A-B-CY in two's complement. CY is 1 exactly when a borrow out of bit 7 occurs and AC is 1 exactly when a borrow out of bit 3 occurs.
- R3: AND, XOR and OR (codes 4, 5, 6) return the bitwise result and clear both CY and AC.
- R4: Compare (code 7) sets every flag as subtract would for A-B, keeps acc_we_o low, and drives result_o equal to acc_i.
- R5: For every operation that updates Z, S and P, the flags follow the 8-bit value. Z is 1 exactly when the value is zero, S copies bit 7, and P is 1 when the number of one bits is even. The flags_o layout is bit 0 CY, bit 1 P, bit 2 AC, bit 3 Z, bit 4 S.
- R6: Increment (code 8) and decrement (code 9) act on opd_i, return B+1 or B-1, and keep acc_we_o low. They set AC to the carry out of bit 3 (increment) or the borrow out of bit 3 (decrement), and leave CY unchanged.
- R7: Rotate left and right (codes 10, 11) circulate bits within the byte and copy the bit that leaves into CY. The through-carry forms (codes 12, 13) shift the old CY in and the departing bit out to CY. Rotates change no flag other than CY.
- R8: Decimal adjust (code 14) first adds 06h when the low nibble is above 9 or AC is 1, and AC becomes the carry out of bit 3 of that step. It then adds 60h when the upper nibble is above 9, CY is 1, or the first step carried out of bit 7. CY ends at 1 if it was 1 or the second step was taken. Z, S and P follow the result.
- R9: Complement accumulator (code 15) returns the inverse of A and leaves all flags unchanged. Complement carry (code 16) inverts CY and set carry (code 17) forces CY to 1. Neither of those two writes the accumulator or changes another flag.
- R10: The flag register resets to 0 and loads on a clock edge only when op_valid_i is high. Codes 18 to 31 leave the flags unchanged, return acc_i and never assert acc_we_o.
- R11: acc_we_o is high exactly when op_valid_i is high and the code is one of 0 to 6 or 10 to 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of the flag register |
| acc_i | input | 8 | Accumulator value |
| opd_i | input | 8 | Second operand, also the target byte of increment and decrement |
| op_i | input | 5 | Operation code |
| op_valid_i | input | 1 | Operation is executed on this clock edge |
| result_o | output | 8 | Result byte, combinational |
| acc_we_o | output | 1 | Write the result into the accumulator |
| flags_o | output | 5 | Registered flags {S, Z, AC, P, CY} |

## Verification
result_o and acc_we_o depend only on the current inputs and the held flags. They are due in the same cycle that the operands are applied. The new flags appear on flags_o one clock edge later. The bench drives each operation just after a rising edge and compares result_o and acc_we_o at the following falling edge. At that same falling edge it compares flags_o with the flags that its model expected after the previous operation, so every flag update is checked exactly one cycle after its stimulus. Idle cycles and unused codes are checked the same way, and the flags must come through them unchanged.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;

  localparam int DW  = 8;
  localparam int NW  = DW / 2;
  localparam int OPW = 5;

  typedef enum logic [OPW-1:0] {
    OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBB = 5'd3,
    OP_AND = 5'd4,  OP_XOR = 5'd5,  OP_OR  = 5'd6,  OP_CMP = 5'd7,
    OP_INC = 5'd8,  OP_DEC = 5'd9,  OP_RLC = 5'd10, OP_RRC = 5'd11,
    OP_RAL = 5'd12, OP_RAR = 5'd13, OP_DAA = 5'd14, OP_CMA = 5'd15,
    OP_CMC = 5'd16, OP_STC = 5'd17
  } alu_op_e;

  // packed MSB first: s=bit4 ... cy=bit0
  typedef struct packed {
    logic s;
    logic z;
    logic ac;
    logic p;
    logic cy;
  } flags_t;

  function automatic logic [DW:0] add_w(input logic [DW-1:0] x, input logic [DW-1:0] y,
                                        input logic c);
    return {1'b0, x} + {1'b0, y} + {{DW{1'b0}}, c};
  endfunction

  function automatic logic [NW:0] add_nib(input logic [NW-1:0] x, input logic [NW-1:0] y,
                                          input logic c);
    return {1'b0, x} + {1'b0, y} + {{NW{1'b0}}, c};
  endfunction

  function automatic flags_t mk_flags(input logic [DW-1:0] v, input logic ac, input logic cy);
    flags_t f;
    f.s  = v[DW-1];
    f.z  = (v == '0);
    f.ac = ac;
    f.p  = ~^v;
    f.cy = cy;
    return f;
  endfunction

endpackage

// File: rtl/byte_alu_core.sv
module byte_alu_core
  import byte_alu_pkg::*;
(
  input  alu_op_e       op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          cy_i,
  output logic [DW-1:0] res_o,
  output logic [DW-1:0] val_o,
  output logic          cy_o,
  output logic          ac_o
);

  logic [DW-1:0] lhs, rhs;
  logic          cin;
  logic [DW:0]   sum;
  logic [NW:0]   nib;
  logic          carry_out, half_carry;

  // operand conditioning: subtraction adds the inverted operand
  always_comb begin
    lhs = a_i;
    rhs = b_i;
    cin = 1'b0;
    unique case (op_i)
      OP_ADC:         cin = cy_i;
      OP_SUB, OP_CMP: begin rhs = ~b_i; cin = 1'b1;  end
      OP_SBB:         begin rhs = ~b_i; cin = ~cy_i; end
      OP_INC:         begin lhs = b_i;  rhs = '0; cin = 1'b1; end
      OP_DEC:         begin lhs = b_i;  rhs = '1; cin = 1'b0; end
      default: ;
    endcase
  end

  assign sum        = add_w(lhs, rhs, cin);
  assign nib        = add_nib(lhs[NW-1:0], rhs[NW-1:0], cin);
  assign carry_out  = sum[DW];
  assign half_carry = nib[NW];

  always_comb begin
    res_o = a_i;
    val_o = sum[DW-1:0];
    cy_o  = cy_i;
    ac_o  = 1'b0;
    unique case (op_i)
      OP_ADD, OP_ADC: begin res_o = sum[DW-1:0]; cy_o = carry_out;  ac_o = half_carry;  end
      OP_SUB, OP_SBB: begin res_o = sum[DW-1:0]; cy_o = ~carry_out; ac_o = ~half_carry; end
      OP_CMP:         begin res_o = a_i;         cy_o = ~carry_out; ac_o = ~half_carry; end
      OP_INC:         begin res_o = sum[DW-1:0]; ac_o = half_carry;  end
      OP_DEC:         begin res_o = sum[DW-1:0]; ac_o = ~half_carry; end
      OP_AND:         begin res_o = a_i & b_i; val_o = a_i & b_i; cy_o = 1'b0; end
      OP_XOR:         begin res_o = a_i ^ b_i; val_o = a_i ^ b_i; cy_o = 1'b0; end
      OP_OR:          begin res_o = a_i | b_i; val_o = a_i | b_i; cy_o = 1'b0; end
      default: ;
    endcase
  end

endmodule

// File: rtl/byte_alu_misc.sv
module byte_alu_misc
  import byte_alu_pkg::*;
(
  input  alu_op_e       op_i,
  input  logic [DW-1:0] a_i,
  input  logic          cy_i,
  input  logic          ac_i,
  output logic [DW-1:0] res_o,
  output logic          cy_o,
  output logic          ac_o
);

  logic          lo_adj, hi_adj;
  logic [DW:0]   step1;
  logic [NW:0]   lo_sum;
  logic [DW-1:0] step2;

  // decimal adjust, two nibble corrections in sequence
  assign lo_adj = (a_i[NW-1:0] > 4'd9) | ac_i;
  assign step1  = add_w(a_i, lo_adj ? 8'h06 : 8'h00, 1'b0);
  assign lo_sum = add_nib(a_i[NW-1:0], lo_adj ? 4'h6 : 4'h0, 1'b0);
  assign hi_adj = (step1[DW-1:NW] > 4'd9) | cy_i | step1[DW];
  assign step2  = step1[DW-1:0] + (hi_adj ? 8'h60 : 8'h00);

  always_comb begin
    res_o = a_i;
    cy_o  = cy_i;
    ac_o  = ac_i;
    unique case (op_i)
      OP_RLC: begin res_o = {a_i[DW-2:0], a_i[DW-1]}; cy_o = a_i[DW-1]; end
      OP_RRC: begin res_o = {a_i[0], a_i[DW-1:1]};    cy_o = a_i[0];    end
      OP_RAL: begin res_o = {a_i[DW-2:0], cy_i};      cy_o = a_i[DW-1]; end
      OP_RAR: begin res_o = {cy_i, a_i[DW-1:1]};      cy_o = a_i[0];    end
      OP_DAA: begin res_o = step2; cy_o = cy_i | hi_adj; ac_o = lo_sum[NW]; end
      OP_CMA: res_o = ~a_i;
      OP_CMC: cy_o = ~cy_i;
      OP_STC: cy_o = 1'b1;
      default: ;
    endcase
  end

endmodule

// File: rtl/byte_alu.sv
module byte_alu
  import byte_alu_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [DW-1:0]  acc_i,
  input  logic [DW-1:0]  opd_i,
  input  logic [OPW-1:0] op_i,
  input  logic           op_valid_i,
  output logic [DW-1:0]  result_o,
  output logic           acc_we_o,
  output logic [4:0]     flags_o
);

  alu_op_e       op;
  flags_t        flags_q, flags_nxt;
  logic [DW-1:0] core_res, core_val, misc_res;
  logic          core_cy, core_ac, misc_cy, misc_ac;
  logic          core_sel, writes_acc;

  assign op       = alu_op_e'(op_i);
  assign core_sel = (op_i <= OP_DEC);

  byte_alu_core u_core (
    .op_i (op), .a_i(acc_i), .b_i(opd_i), .cy_i(flags_q.cy),
    .res_o(core_res), .val_o(core_val), .cy_o(core_cy), .ac_o(core_ac)
  );

  byte_alu_misc u_misc (
    .op_i (op), .a_i(acc_i), .cy_i(flags_q.cy), .ac_i(flags_q.ac),
    .res_o(misc_res), .cy_o(misc_cy), .ac_o(misc_ac)
  );

  always_comb begin
    writes_acc = 1'b0;
    flags_nxt  = flags_q;
    result_o   = acc_i;
    if (core_sel) begin
      result_o   = core_res;
      flags_nxt  = mk_flags(core_val, core_ac, core_cy);
      writes_acc = (op_i <= OP_OR);
    end else begin
      unique case (op)
        OP_RLC, OP_RRC, OP_RAL, OP_RAR: begin
          result_o     = misc_res;
          flags_nxt.cy = misc_cy;
          writes_acc   = 1'b1;
        end
        OP_DAA: begin
          result_o   = misc_res;
          flags_nxt  = mk_flags(misc_res, misc_ac, misc_cy);
          writes_acc = 1'b1;
        end
        OP_CMA: begin
          result_o   = misc_res;
          writes_acc = 1'b1;
        end
        OP_CMC, OP_STC: flags_nxt.cy = misc_cy;
        default: ;
      endcase
    end
  end

  assign acc_we_o = op_valid_i & writes_acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          flags_q <= '0;
    else if (op_valid_i) flags_q <= flags_nxt;
  end

  assign flags_o = flags_q;

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid_i |=> flags_q == $past(flags_q)); // R10
  AST_LOGIC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid_i && (op_i == OP_AND || op_i == OP_XOR || op_i == OP_OR)
    |=> !flags_q.cy && !flags_q.ac); // R3
  AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid_i && op_i == OP_CMP |-> !acc_we_o); // R4
  AST_CMP_BORROW: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid_i && op_i == OP_CMP |=> flags_q.cy == ($past(acc_i) < $past(opd_i))); // R4
  AST_INCDEC_KEEP_CY: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid_i && (op_i == OP_INC || op_i == OP_DEC) |=> flags_q.cy == $past(flags_q.cy)); // R6
  AST_STC_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid_i && op_i == OP_STC |=> flags_q.cy); // R9
  AST_ZERO_ADD: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid_i && op_i == OP_ADD && result_o == '0 |=> flags_q.z); // R5

endmodule

// File: tb/byte_alu_bench.sv
`timescale 1ns/1ps
module byte_alu_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] acc = 8'h00, opd = 8'h00;
  logic [4:0] op = 5'd0;
  logic       vld = 1'b0;
  wire  [7:0] res;
  wire        we;
  wire  [4:0] fl;

  int total = 0;
  int bad   = 0;
  int mflags = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  byte_alu u_byte_alu (
    .clk(clk), .rst_n(rst_n), .acc_i(acc), .opd_i(opd), .op_i(op),
    .op_valid_i(vld), .result_o(res), .acc_we_o(we), .flags_o(fl)
  );

  function automatic int even_ones(int v);
    int n = 0;
    for (int i = 0; i < 8; i++) if (((v >> i) & 1) == 1) n++;
    return (n % 2 == 0) ? 1 : 0;
  endfunction

  function automatic string req_of(int o);
    if (o <= 1) return "R1";
    if (o <= 3) return "R2";
    if (o <= 6) return "R3";
    if (o == 7) return "R4";
    if (o <= 9) return "R6";
    if (o <= 13) return "R7";
    if (o == 14) return "R8";
    if (o <= 17) return "R9";
    return "R10";
  endfunction

  // reference: result, accumulator write, flags after the operation
  task automatic model(input int o, input int a, input int b, input int f,
                       output int r, output int w, output int fo);
    int cy = f & 1;
    int ac = (f >> 2) & 1;
    int v  = a;
    int full = 0;
    int t, hi;
    r = a; w = 0; fo = f;
    case (o)
      0, 1: begin
        t = a + b + ((o == 1) ? cy : 0);
        ac = ((a % 16) + (b % 16) + ((o == 1) ? cy : 0)) > 15;
        cy = t > 255; r = t % 256; v = r; w = 1; full = 1;
      end
      2, 3, 7: begin
        t = a - b - ((o == 3) ? cy : 0);
        ac = ((a % 16) - (b % 16) - ((o == 3) ? cy : 0)) < 0;
        cy = t < 0; v = (t + 512) % 256;
        r = (o == 7) ? a : v; w = (o != 7); full = 1;
      end
      4: begin r = a & b; v = r; cy = 0; ac = 0; w = 1; full = 1; end
      5: begin r = a ^ b; v = r; cy = 0; ac = 0; w = 1; full = 1; end
      6: begin r = a | b; v = r; cy = 0; ac = 0; w = 1; full = 1; end
      8: begin r = (b + 1) % 256; v = r; ac = (b % 16) == 15; full = 1; end
      9: begin r = (b + 255) % 256; v = r; ac = (b % 16) == 0; full = 1; end
      10: begin r = ((a * 2) % 256) + a / 128; cy = a / 128; w = 1; end
      11: begin r = (a / 2) + (a % 2) * 128; cy = a % 2; w = 1; end
      12: begin r = ((a * 2) % 256) + cy; cy = a / 128; w = 1; end
      13: begin r = (a / 2) + cy * 128; cy = a % 2; w = 1; end
      14: begin
        t = a;
        if ((a % 16) > 9 || ac == 1) begin ac = ((a % 16) + 6) > 15; t = a + 6; end
        else ac = 0;
        hi = (t % 256) / 16;
        if (hi > 9 || cy == 1 || t > 255) begin t = (t % 256) + 96; cy = 1; end
        r = t % 256; v = r; w = 1; full = 1;
      end
      15: begin r = 255 - a; w = 1; end
      16: cy = 1 - cy;
      17: cy = 1;
      default: ;
    endcase
    if (full == 1)
      fo = ((v >= 128) ? 16 : 0) + ((v == 0) ? 8 : 0) + ac * 4 + even_ones(v) * 2 + cy;
    else
      fo = (f & 30) | cy;
  endtask

  task automatic run(input int o, input int a, input int b, input int v, input string tag);
    int r, w, fo;
    @(posedge clk);
    #1;
    op = o[4:0]; acc = a[7:0]; opd = b[7:0]; vld = v[0];
    @(negedge clk);
    model(o, a, b, mflags, r, w, fo);
    if (v == 0) w = 0;
    total++;
    if (res !== r[7:0] || we !== w[0] || fl !== mflags[4:0]) begin
      bad++;
      $display("FAIL %s op=%0d a=%02h b=%02h actual res=%02h we=%0b fl=%05b expected res=%02h we=%0b fl=%05b",
               tag, o, a, b, res, we, fl, r[7:0], w[0], mflags[4:0]);
    end
    if (v != 0) mflags = fo;
  endtask

  task automatic flag_chk(input int exp, input string tag);
    @(negedge clk);
    total++;
    if (fl !== exp[4:0]) begin
      bad++;
      $display("FAIL %s flags actual=%05b expected=%05b", tag, fl, exp[4:0]);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    // R10: reset value
    flag_chk(0, "R10");
    @(posedge clk); #1 rst_n = 1'b1;

    run(0, 8'h80, 8'h80, 1, "R1");   // 0, CY=1, Z=1
    run(0, 8'h0F, 8'h01, 1, "R1");   // AC from bit 3
    run(1, 8'h10, 8'h20, 1, "R1");   // uses held CY
    run(2, 8'h10, 8'h20, 1, "R2");   // borrow
    run(3, 8'h30, 8'h0F, 1, "R2");   // borrow in and nibble borrow
    run(7, 8'h42, 8'h42, 1, "R4");   // equal: Z set, no write
    run(7, 8'h01, 8'h02, 1, "R4");   // below: CY set
    run(17, 8'h00, 8'h00, 1, "R9");
    run(4, 8'hF0, 8'h3C, 1, "R3");   // CY cleared after STC
    run(5, 8'hAA, 8'hAA, 1, "R5");   // zero, even parity
    run(6, 8'h80, 8'h01, 1, "R5");   // sign set, even parity
    run(6, 8'h07, 8'h00, 1, "R5");   // odd parity
    run(17, 8'h00, 8'h00, 1, "R9");
    run(8, 8'h55, 8'hFF, 1, "R6");   // wraps to 0, CY kept
    run(9, 8'h55, 8'h00, 1, "R6");   // wraps to FF, nibble borrow
    run(10, 8'h81, 8'h00, 1, "R7");
    run(11, 8'h01, 8'h00, 1, "R7");
    run(12, 8'h40, 8'h00, 1, "R7");
    run(13, 8'h01, 8'h00, 1, "R7");
    run(0, 8'h19, 8'h28, 1, "R8");   // prepare BCD sum 41 -> AC
    run(14, 8'h41, 8'h00, 1, "R8");
    run(14, 8'h9A, 8'h00, 1, "R8");
    run(16, 8'h12, 8'h00, 1, "R9");
    run(15, 8'h5A, 8'h00, 1, "R9");
    run(17, 8'h00, 8'h00, 0, "R10"); // idle: no flag change
    run(20, 8'h33, 8'h44, 1, "R10"); // unused code
    run(0, 8'h01, 8'h01, 0, "R11");  // no write when not valid
    flag_chk(mflags, "R10");

    for (int i = 0; i < 3000; i++) begin
      int o = $urandom_range(0, 19);
      int a = $urandom_range(0, 255);
      int b = $urandom_range(0, 255);
      int v = ($urandom_range(0, 7) != 0) ? 1 : 0;
      run(o, a, b, v, req_of(o));
    end
    flag_chk(mflags, "R10");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule